// File: doc/BRIEF.md
# Shared-ALU Multi-Cycle Processor Datapath

This block is the datapath of a small 32-bit load/store processor that spends several clock cycles on each instruction. It has one ALU and one memory port. The ALU computes the next sequential PC, the branch target and the effective address of a load or store in different cycles. The memory port fetches instructions and also moves data. Values that must survive from one cycle to the next sit in internal registers: the PC, an instruction register, a memory data register, two operand latches and an ALU result latch. A 32-entry register file, a sign extender and the selection multiplexers complete the datapath.

The block makes no decisions of its own. An external controller drives every enable and select on every cycle. It uses the exposed opcode field, function field and zero flag to choose its next step. Memory reads are combinational: `mem_rdata` must be valid in the same cycle that `mem_addr` is presented. Writes happen on the clock edge at which the external memory samples `mem_we`.

Top module: `mc_datapath`

## Requirements
- R1: While `rst_n` is low, the PC, instruction register and all internal latches clear to zero. After release, with `addr_sel`=0, `mem_addr` reads 0 and `opcode`/`funct` read 0.
- R2: `mem_addr` equals the PC when `addr_sel`=0 and the ALU result latch when `addr_sel`=1.
- R3: The ALU first operand is the PC when `srca_sel`=0 and the A latch when `srca_sel`=1. `alu_op` encodes the function: 000 bitwise AND, 001 bitwise OR, 010 add, 110 subtract, 111 signed set-less-than (result 1 or 0). `zero` is high exactly when the live ALU result is all zeros.
- R4: The ALU second operand is selected by `srcb_sel`: 00 the B latch, 01 the constant 4, 10 IR[15:0] sign-extended to 32 bits, 11 that sign-extended value shifted left by 2.
- R5: When the PC is written, its new value is selected by `pc_src`: 00 the live ALU result, 01 the ALU result latch, 10 the jump target {PC[31:28], IR[25:0], 2'b00}, 11 the current PC (no change).
- R6: The PC loads on a clock edge where `pc_wr` is high, or where `pc_wr_zero` is high and `zero` is high. Otherwise it keeps its value.
- R7: The instruction register loads `mem_rdata` only on edges where `ir_load` is high. `opcode` is IR[31:26] and `funct` is IR[5:0].
- R8: On an edge with `rf_we` high, the register file is written. The destination is IR[15:11] when `dst_sel`=1 and IR[20:16] when `dst_sel`=0. The data is the memory data register when `wb_sel`=1 and the ALU result latch when `wb_sel`=0. Register 0 reads as zero and ignores writes.
- R9: On every edge, the A and B latches capture the registers addressed by IR[25:21] and IR[20:16], the ALU result latch captures the live ALU result, and the memory data register captures `mem_rdata`. `mem_wdata` is the B latch. `mem_re`/`mem_we` follow `mem_rd_req`/`mem_wr_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_wr | input | 1 | Unconditional PC write |
| pc_wr_zero | input | 1 | PC write qualified by the zero flag |
| pc_src | input | 2 | Next-PC source select |
| addr_sel | input | 1 | Memory address source: PC or ALU result latch |
| ir_load | input | 1 | Instruction register load enable |
| rf_we | input | 1 | Register file write enable |
| dst_sel | input | 1 | Destination field select: rd or rt |
| wb_sel | input | 1 | Write-back data select: ALU latch or memory data register |
| srca_sel | input | 1 | ALU first operand select |
| srcb_sel | input | 2 | ALU second operand select |
| alu_op | input | 3 | ALU function code |
| mem_rd_req | input | 1 | Memory read request from the controller |
| mem_wr_req | input | 1 | Memory write request from the controller |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data (B latch) |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |
| zero | output | 1 | Live ALU result is zero |

## Verification
The hardest state to reach from the ports is the register file contents, because nothing exposes them directly. The stimulus first loads the instruction register with a word whose rt field names the target register. It then presents the data word so that the memory data register captures it, and commits the value with a write-back cycle. To read a register back, the stimulus loads an instruction naming it in the rs and rt fields and waits one cycle for the latches. The B latch then appears on `mem_wdata`. The A latch is checked by routing it through the ALU into the PC, where `mem_addr` shows the result. The same route checks every ALU function on chosen register pairs and both outcomes of the zero-qualified PC write.

// File: rtl/mc_datapath.sv
module mc_datapath #(
  parameter int XW = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pc_wr,
  input  logic          pc_wr_zero,
  input  logic [1:0]    pc_src,
  input  logic          addr_sel,
  input  logic          ir_load,
  input  logic          rf_we,
  input  logic          dst_sel,
  input  logic          wb_sel,
  input  logic          srca_sel,
  input  logic [1:0]    srcb_sel,
  input  logic [2:0]    alu_op,
  input  logic          mem_rd_req,
  input  logic          mem_wr_req,
  output logic [XW-1:0] mem_addr,
  output logic [XW-1:0] mem_wdata,
  input  logic [XW-1:0] mem_rdata,
  output logic          mem_re,
  output logic          mem_we,
  output logic [5:0]    opcode,
  output logic [5:0]    funct,
  output logic          zero
);
  localparam int NREG = 32;
  localparam int IMMW = 16;

  logic [XW-1:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_q;
  logic [XW-1:0] rf [NREG];
  logic [XW-1:0] imm_x, src_a, src_b, alu_y, pc_nxt, wb_data;
  logic [4:0]    rs_f, rt_f, rd_f, wr_idx;
  logic          pc_en;

  assign rs_f   = ir_q[25:21];
  assign rt_f   = ir_q[20:16];
  assign rd_f   = ir_q[15:11];
  assign opcode = ir_q[31:26];
  assign funct  = ir_q[5:0];

  assign imm_x     = {{(XW-IMMW){ir_q[IMMW-1]}}, ir_q[IMMW-1:0]};
  assign src_a     = srca_sel ? a_q : pc_q;
  assign mem_addr  = addr_sel ? alu_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_re    = mem_rd_req;
  assign mem_we    = mem_wr_req;
  assign wr_idx    = dst_sel ? rd_f : rt_f;
  assign wb_data   = wb_sel ? mdr_q : alu_q;

  always_comb begin
    case (srcb_sel)
      2'b00:   src_b = b_q;
      2'b01:   src_b = {{(XW-3){1'b0}}, 3'd4};
      2'b10:   src_b = imm_x;
      default: src_b = imm_x << 2;
    endcase
  end

  always_comb begin
    case (alu_op)
      3'b000:  alu_y = src_a & src_b;
      3'b001:  alu_y = src_a | src_b;
      3'b010:  alu_y = src_a + src_b;
      3'b110:  alu_y = src_a - src_b;
      3'b111:  alu_y = {{(XW-1){1'b0}}, $signed(src_a) < $signed(src_b)};
      default: alu_y = '0;
    endcase
  end

  assign zero = (alu_y == '0);

  always_comb begin
    case (pc_src)
      2'b00:   pc_nxt = alu_y;
      2'b01:   pc_nxt = alu_q;
      2'b10:   pc_nxt = {pc_q[XW-1:XW-4], ir_q[25:0], 2'b00};
      default: pc_nxt = pc_q;
    endcase
  end

  assign pc_en = pc_wr | (pc_wr_zero & zero);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      ir_q  <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      alu_q <= '0;
    end else begin
      if (pc_en)   pc_q <= pc_nxt;
      if (ir_load) ir_q <= mem_rdata;
      mdr_q <= mem_rdata;
      a_q   <= rf[rs_f];
      b_q   <= rf[rt_f];
      alu_q <= alu_y;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (rf_we && wr_idx != 5'd0) begin
      rf[wr_idx] <= wb_data;
    end
  end

  p_pc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_wr && !pc_wr_zero) |=> $stable(pc_q));

  p_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_wr && pc_src == 2'b10) |=>
      (pc_q[XW-1:XW-4] == $past(pc_q[XW-1:XW-4]) && pc_q[1:0] == 2'b00));

  p_ir_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_load |=> $stable(ir_q));

  p_r0_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_f == 5'd0) |=> (a_q == '0));

  p_mdr_every_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mdr_q == $past(mem_rdata)));
endmodule

// File: tb/tb_mc_datapath.sv
module tb_mc_datapath;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic rst_n, pc_wr, pc_wr_zero, addr_sel, ir_load, rf_we, dst_sel, wb_sel;
  logic srca_sel, mem_rd_req, mem_wr_req, mem_re, mem_we, zero;
  logic [1:0] pc_src, srcb_sel;
  logic [2:0] alu_op;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [5:0] opcode, funct;

  int total = 0;
  int bad = 0;
  logic [31:0] vals [32];

  mc_datapath dut (
    .clk(clk), .rst_n(rst_n), .pc_wr(pc_wr), .pc_wr_zero(pc_wr_zero),
    .pc_src(pc_src), .addr_sel(addr_sel), .ir_load(ir_load), .rf_we(rf_we),
    .dst_sel(dst_sel), .wb_sel(wb_sel), .srca_sel(srca_sel), .srcb_sel(srcb_sel),
    .alu_op(alu_op), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_re(mem_re), .mem_we(mem_we), .opcode(opcode), .funct(funct), .zero(zero)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    pc_wr = 0; pc_wr_zero = 0; pc_src = 0; addr_sel = 0; ir_load = 0;
    rf_we = 0; dst_sel = 0; wb_sel = 0; srca_sel = 0; srcb_sel = 0;
    alu_op = 0; mem_rd_req = 0; mem_wr_req = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1; idle(); #1;
  endtask

  task automatic ld_ir(input logic [31:0] w);
    mem_rdata = w; ir_load = 1; tick();
  endtask

  task automatic put_reg(input logic [4:0] r, input logic [31:0] v);
    ld_ir({6'h23, 5'd0, r, 16'h0000});
    mem_rdata = v; tick();
    wb_sel = 1; dst_sel = 0; rf_we = 1; tick();
    if (r != 5'd0) vals[r] = v;
  endtask

  task automatic rd_pair(input logic [4:0] rs, input logic [4:0] rt);
    ld_ir({6'h00, rs, rt, 5'd0, 5'd0, 6'h20});
    tick();
  endtask

  function automatic logic [31:0] ref_alu(input logic [2:0] op, input logic [31:0] x, input logic [31:0] y);
    case (op)
      3'b000: return x & y;
      3'b001: return x | y;
      3'b010: return x + y;
      3'b110: return x - y;
      3'b111: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  initial begin
    #(CLK_NS * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] p, e;
    logic [2:0] ops [5];
    logic [4:0] pa [7];
    logic [4:0] pb [7];
    ops[0] = 3'b000; ops[1] = 3'b001; ops[2] = 3'b010; ops[3] = 3'b110; ops[4] = 3'b111;
    pa[0] = 2; pb[0] = 3;  pa[1] = 3; pb[1] = 2;  pa[2] = 4; pb[2] = 5;
    pa[3] = 5; pb[3] = 4;  pa[4] = 2; pb[4] = 6;  pa[5] = 4; pb[5] = 4;
    pa[6] = 0; pb[6] = 3;
    for (int i = 0; i < 32; i++) vals[i] = 32'h0;
    idle(); mem_rdata = 32'h0; rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1; #1;
    // R1 reset state
    chk("R1 pc after reset", mem_addr, 32'h0);
    chk("R1 opcode after reset", {26'h0, opcode}, 32'h0);
    chk("R1 funct after reset", {26'h0, funct}, 32'h0);

    // R8 write every register through the memory data register, read back via B
    for (int r = 0; r < 32; r++) put_reg(5'(r), (32'(r) * 32'h01000193) ^ 32'h5A5A0000);
    for (int r = 0; r < 32; r++) begin
      rd_pair(5'(r), 5'(r));
      chk($sformatf("R8 readback reg %0d", r), mem_wdata, vals[r]);
    end

    // R9 write data and enables pass through
    rd_pair(5'd7, 5'd11);
    mem_wr_req = 1; #1;
    chk("R9 mem_we follows request", {31'h0, mem_we}, 32'h1);
    chk("R9 mem_re idle", {31'h0, mem_re}, 32'h0);
    chk("R9 mem_wdata is B latch", mem_wdata, vals[11]);
    idle(); mem_rd_req = 1; #1;
    chk("R9 mem_re follows request", {31'h0, mem_re}, 32'h1);
    idle(); #1;

    // R3 ALU functions on chosen operand pairs
    put_reg(5'd2, 32'd5);
    put_reg(5'd3, 32'hFFFF_FFFD);
    put_reg(5'd4, 32'h8000_0000);
    put_reg(5'd5, 32'h7FFF_FFFF);
    put_reg(5'd6, 32'd5);
    for (int k = 0; k < 7; k++) begin
      for (int o = 0; o < 5; o++) begin
        rd_pair(pa[k], pb[k]);
        e = ref_alu(ops[o], vals[pa[k]], vals[pb[k]]);
        srca_sel = 1; srcb_sel = 2'b00; alu_op = ops[o]; #1;
        chk($sformatf("R3 zero op%0d pair%0d", ops[o], k), {31'h0, zero}, {31'h0, e == 32'h0});
        pc_src = 2'b00; pc_wr = 1; tick();
        chk($sformatf("R3 result op%0d pair%0d", ops[o], k), mem_addr, e);
      end
    end

    // R4 second operand selection
    ld_ir({6'h08, 5'd2, 5'd0, 16'hFFF0}); tick();
    srca_sel = 1; srcb_sel = 2'b10; alu_op = 3'b010; pc_wr = 1; tick();
    chk("R4 negative immediate", mem_addr, 32'hFFFF_FFF5);
    srca_sel = 1; srcb_sel = 2'b11; alu_op = 3'b010; pc_wr = 1; tick();
    chk("R4 negative immediate shifted", mem_addr, 32'hFFFF_FFC5);
    ld_ir({6'h08, 5'd2, 5'd0, 16'h0010}); tick();
    srca_sel = 1; srcb_sel = 2'b10; alu_op = 3'b010; pc_wr = 1; tick();
    chk("R4 positive immediate", mem_addr, 32'd21);
    srca_sel = 1; srcb_sel = 2'b11; alu_op = 3'b010; pc_wr = 1; tick();
    chk("R4 positive immediate shifted", mem_addr, 32'd69);
    p = mem_addr;
    srca_sel = 0; srcb_sel = 2'b01; alu_op = 3'b010; pc_wr = 1; tick();
    chk("R4 constant four on PC", mem_addr, p + 32'd4);

    // R5 and R2 latched result as PC source and address
    srca_sel = 1; srcb_sel = 2'b10; alu_op = 3'b010; tick();
    addr_sel = 1; #1;
    chk("R2 address from result latch", mem_addr, 32'd21);
    pc_src = 2'b01; pc_wr = 1; tick();
    chk("R5 PC from result latch", mem_addr, 32'd21);
    pc_src = 2'b11; pc_wr = 1; tick();
    chk("R5 select 11 keeps PC", mem_addr, 32'd21);

    // R5 jump target
    ld_ir({6'h02, 26'h0ABCDEF}); tick();
    srca_sel = 1; srcb_sel = 2'b01; alu_op = 3'b010; pc_wr = 1; tick();
    chk("R5 setup PC", mem_addr, 32'h8000_0003);
    pc_src = 2'b10; pc_wr = 1; tick();
    chk("R5 jump target", mem_addr, {4'h8, 26'h0ABCDEF, 2'b00});

    // R6 zero-qualified PC write, taken and not taken
    rd_pair(5'd2, 5'd6);
    p = mem_addr;
    srca_sel = 0; srcb_sel = 2'b01; alu_op = 3'b010; tick();
    srca_sel = 1; srcb_sel = 2'b00; alu_op = 3'b110; #1;
    chk("R6 equal operands give zero", {31'h0, zero}, 32'h1);
    pc_wr_zero = 1; pc_src = 2'b01; tick();
    chk("R6 taken when zero", mem_addr, p + 32'd4);
    rd_pair(5'd2, 5'd3);
    p = mem_addr;
    srca_sel = 0; srcb_sel = 2'b01; alu_op = 3'b010; tick();
    srca_sel = 1; srcb_sel = 2'b00; alu_op = 3'b110; #1;
    chk("R6 unequal operands not zero", {31'h0, zero}, 32'h0);
    pc_wr_zero = 1; pc_src = 2'b01; tick();
    chk("R6 not taken keeps PC", mem_addr, p);

    // R7 instruction register load gating and fields
    ld_ir(32'hAC00_002A);
    chk("R7 opcode field", {26'h0, opcode}, 32'h2B);
    chk("R7 funct field", {26'h0, funct}, 32'h2A);
    mem_rdata = 32'h1234_5678; tick();
    chk("R7 opcode held without load", {26'h0, opcode}, 32'h2B);
    chk("R7 funct held without load", {26'h0, funct}, 32'h2A);

    // R8 rd destination with result-latch data
    ld_ir({6'h00, 5'd0, 5'd9, 5'd17, 5'd0, 6'h20});
    p = mem_addr;
    srca_sel = 0; srcb_sel = 2'b01; alu_op = 3'b010; tick();
    dst_sel = 1; wb_sel = 0; rf_we = 1; tick();
    rd_pair(5'd9, 5'd17);
    chk("R8 rd destination written", mem_wdata, p + 32'd4);
    rd_pair(5'd17, 5'd9);
    chk("R8 rt untouched by rd write", mem_wdata, vals[9]);
    put_reg(5'd0, 32'hDEAD_BEEF);
    rd_pair(5'd0, 5'd0);
    chk("R8 register zero ignores write", mem_wdata, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule